// File: doc/BRIEF.md
# Skip-Instruction Resolver

This unit settles the conditional skip instructions of a small 8-bit RISC pipeline. Each skip is turned into a relative branch request whose word offset is 0, 1 or 2. The offset is 0 when the skip condition fails. It is 1 when the condition holds and the instruction that follows is one word long, and 2 when it holds and that instruction is two words long. Three skip families are handled. The first compares two general registers for equality. The second tests one chosen bit of a general register, for either a clear or a set bit. The third tests one chosen bit of an I/O register, again for clear or set.

The decoder presents a skip class with its operands for one cycle while `ready` is high. The register families raise their branch request on the next cycle. The I/O family first spends one stall cycle waiting for its I/O read value and requests one cycle later. A taken skip (non-zero offset) is followed by two flush cycles, which discard the younger instructions already fetched. An untaken skip is issued as a zero-offset branch request and returns straight to idle.

Top module: `skip_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the unit to idle: `ready`=1 and `br_req`, `br_offset`, `flush` and `stall` all 0, even if a skip is in progress.
- R2: The unit accepts a skip only at an edge where `ready` and `skip_valid` are both high. The class codes are 0 = register equality, 1 = register bit clear, 2 = register bit set, 3 = I/O bit clear and 4 = I/O bit set. Codes 5 to 7 are ignored: `ready` stays 1 and no request, stall or flush follows.
- R3: For class 0 the condition holds exactly when `reg_a` equals `reg_b`.
- R4: For classes 1 and 2 the condition holds when bit `bit_sel` (0 to 7) of `reg_a` is 0 for class 1, or 1 for class 2.
- R5: For classes 3 and 4 the condition holds when bit `bit_sel` of `io_data`, sampled at the end of the stall cycle, is 0 for class 3 or 1 for class 4.
- R6: `br_offset` during the request cycle is 0 if the condition fails, 1 if it holds with `next_long`=0, and 2 if it holds with `next_long`=1. It is never 3.
- R7: For a register skip, `br_req` is high for exactly the one cycle after the issue cycle. Counting from the issue cycle up to the cycle before `ready` returns, the skip lasts 2 clocks when not taken and 4 when taken.
- R8: For an I/O skip, `stall` is high for exactly the one cycle after issue and `br_req` is high in the following cycle. The skip lasts 3 clocks when not taken and 5 when taken.
- R9: A request with a non-zero offset is followed by exactly two `flush` cycles. A zero-offset request is followed directly by `ready`, with no flush.
- R10: `reg_a`, `reg_b`, `bit_sel` and `next_long` are sampled only at the issue edge, and `io_data` only at the edge ending the stall cycle. Changes to them at other times do not alter `br_offset`.
- R11: While the unit is busy (`ready`=0), `skip_valid` is ignored. At most one of `stall`, `br_req` and `flush` is high in any cycle, and none of them is high while `ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| skip_valid | input | 1 | A decoded skip is presented this cycle |
| skip_kind | input | 3 | Skip class code (0..4 valid) |
| reg_a | input | 8 | First general-register operand |
| reg_b | input | 8 | Second general-register operand (equality class) |
| bit_sel | input | 3 | Index of the tested bit |
| next_long | input | 1 | Following instruction is two words long |
| io_data | input | 8 | I/O register read value, valid during the stall cycle |
| ready | output | 1 | Idle and able to accept a skip |
| br_req | output | 1 | Relative branch request strobe |
| br_offset | output | 2 | Relative word offset of the request |
| flush | output | 1 | Discard younger in-flight instructions |
| stall | output | 1 | Hold younger instructions while the I/O read completes |

## Verification
The assertions assume that the decoder honours `ready` and that reset is held for at least one edge before checking starts. They also assume that `io_data` carries the real I/O value in the cycle where `stall` is high. The stimulus issues each skip only in a cycle where `ready` is observed high. It then drives random `skip_valid` pulses, random class codes and random operand values during the busy cycles. The correct I/O value is placed on `io_data` only in the stall cycle, and random data is driven there at every other time. In this way the stimulus also probes the R10 and R11 claims that inputs are ignored outside their sampling windows.

// File: rtl/skip_ctrl_pkg.sv
package skip_ctrl_pkg;

    typedef enum logic [2:0] {
        K_CMP_EQ    = 3'd0,
        K_RBIT_CLR  = 3'd1,
        K_RBIT_SET  = 3'd2,
        K_IOBIT_CLR = 3'd3,
        K_IOBIT_SET = 3'd4
    } skip_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_IO_WAIT = 3'd1,
        ST_RESOLVE = 3'd2,
        ST_FLUSH_A = 3'd3,
        ST_FLUSH_B = 3'd4
    } skip_state_e;

    function automatic logic is_reg_kind(input logic [2:0] k);
        return (k == K_CMP_EQ) || (k == K_RBIT_CLR) || (k == K_RBIT_SET);
    endfunction

    function automatic logic is_io_kind(input logic [2:0] k);
        return (k == K_IOBIT_CLR) || (k == K_IOBIT_SET);
    endfunction

    // word offset of the equivalent relative branch
    function automatic logic [1:0] offset_for(input logic cond, input logic long_next);
        if (!cond) return 2'd0;
        return long_next ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/skip_bit_test.sv
module skip_bit_test #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    input  logic              want_set,
    output logic              hit
);
    always_comb begin
        hit = (data[idx] == want_set);
    end
endmodule

// File: rtl/skip_reg_cond.sv
module skip_reg_cond
    import skip_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [2:0]        kind,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IDX_W-1:0]  idx,
    output logic              cond
);
    logic [DATA_W-1:0] same_bit;
    logic              bit_hit;

    // per-bit equality, reduced below
    for (genvar g = 0; g < DATA_W; g++) begin : g_eq
        assign same_bit[g] = ~(opa[g] ^ opb[g]);
    end

    skip_bit_test #(.DATA_W(DATA_W)) u_bit (
        .data     (opa),
        .idx      (idx),
        .want_set (kind == K_RBIT_SET),
        .hit      (bit_hit)
    );

    always_comb begin
        if (kind == K_CMP_EQ) cond = &same_bit;
        else                  cond = bit_hit;
    end
endmodule

// File: rtl/skip_ctrl.sv
module skip_ctrl
    import skip_ctrl_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              skip_valid,
    input  logic [2:0]        skip_kind,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic              next_long,
    input  logic [DATA_W-1:0] io_data,
    output logic              ready,
    output logic              br_req,
    output logic [1:0]        br_offset,
    output logic              flush,
    output logic              stall
);
    typedef struct packed {
        skip_state_e      st;
        logic [1:0]       off;
        logic [IDX_W-1:0] idx;
        logic             want_set;
        logic             long_next;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic reg_cond;
    logic io_hit;

    skip_reg_cond #(.DATA_W(DATA_W)) u_reg_cond (
        .kind (skip_kind),
        .opa  (reg_a),
        .opb  (reg_b),
        .idx  (bit_sel),
        .cond (reg_cond)
    );

    skip_bit_test #(.DATA_W(DATA_W)) u_io_bit (
        .data     (io_data),
        .idx      (ctl_q.idx),
        .want_set (ctl_q.want_set),
        .hit      (io_hit)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (skip_valid && is_reg_kind(skip_kind)) begin
                    ctl_d.st  = ST_RESOLVE;
                    ctl_d.off = offset_for(reg_cond, next_long);
                end else if (skip_valid && is_io_kind(skip_kind)) begin
                    ctl_d.st        = ST_IO_WAIT;
                    ctl_d.idx       = bit_sel;
                    ctl_d.want_set  = (skip_kind == K_IOBIT_SET);
                    ctl_d.long_next = next_long;
                end
            end
            ST_IO_WAIT: begin
                ctl_d.st  = ST_RESOLVE;
                ctl_d.off = offset_for(io_hit, ctl_q.long_next);
            end
            ST_RESOLVE: ctl_d.st = (ctl_q.off != 2'd0) ? ST_FLUSH_A : ST_IDLE;
            ST_FLUSH_A: ctl_d.st = ST_FLUSH_B;
            ST_FLUSH_B: ctl_d.st = ST_IDLE;
            default:    ctl_d.st = ST_IDLE;
        endcase
        if (rst) ctl_d = '0;
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign ready     = (ctl_q.st == ST_IDLE);
    assign stall     = (ctl_q.st == ST_IO_WAIT);
    assign br_req    = (ctl_q.st == ST_RESOLVE);
    assign br_offset = br_req ? ctl_q.off : 2'd0;
    assign flush     = (ctl_q.st == ST_FLUSH_A) || (ctl_q.st == ST_FLUSH_B);

    assert_unknown_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (ready && skip_valid && !is_reg_kind(skip_kind) && !is_io_kind(skip_kind)) |=> ready);

    assert_offset_range_R6: assert property (@(posedge clk) disable iff (rst)
        br_req |-> (br_offset != 2'd3));

    assert_reg_request_next_R7: assert property (@(posedge clk) disable iff (rst)
        (ready && skip_valid && is_reg_kind(skip_kind)) |=> br_req);

    assert_request_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        br_req |=> !br_req);

    assert_io_stall_next_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && skip_valid && is_io_kind(skip_kind)) |=> (stall && !ready));

    assert_stall_then_request_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> br_req);

    assert_taken_flushes_R9: assert property (@(posedge clk) disable iff (rst)
        (br_req && br_offset != 2'd0) |=> flush);

    assert_flush_pair_R9: assert property (@(posedge clk) disable iff (rst)
        (flush && !$past(flush)) |=> flush);

    assert_untaken_no_flush_R9: assert property (@(posedge clk) disable iff (rst)
        (br_req && br_offset == 2'd0) |=> (ready && !flush));

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stall, br_req, flush}) && !(ready && (stall || br_req || flush)));

endmodule

// File: tb/skip_ctrl_test.sv
module skip_ctrl_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       skip_valid;
    logic [2:0] skip_kind;
    logic [7:0] reg_a, reg_b, io_data;
    logic [2:0] bit_sel;
    logic       next_long;
    logic       ready, br_req, flush, stall;
    logic [1:0] br_offset;

    int vectors = 0;
    int miscompares = 0;

    always #5 clk = ~clk;

    skip_ctrl uut (
        .clk(clk), .rst(rst), .skip_valid(skip_valid), .skip_kind(skip_kind),
        .reg_a(reg_a), .reg_b(reg_b), .bit_sel(bit_sel), .next_long(next_long),
        .io_data(io_data), .ready(ready), .br_req(br_req), .br_offset(br_offset),
        .flush(flush), .stall(stall)
    );

    function automatic logic [1:0] exp_offset(input logic [2:0] k, input logic [7:0] a,
                                              input logic [7:0] b, input logic [2:0] i,
                                              input logic [7:0] io, input logic lng);
        logic c;
        case (k)
            3'd0:    c = (a == b);
            3'd1:    c = (a[i] == 1'b0);
            3'd2:    c = (a[i] == 1'b1);
            3'd3:    c = (io[i] == 1'b0);
            default: c = (io[i] == 1'b1);
        endcase
        if (!c) return 2'd0;
        return lng ? 2'd2 : 2'd1;
    endfunction

    task automatic chk(input string tag, input logic e_rdy, input logic e_req,
                       input logic [1:0] e_off, input logic e_fl, input logic e_st);
        logic [5:0] act, exp;
        act = {ready, br_req, br_offset, flush, stall};
        exp = {e_rdy, e_req, e_off, e_fl, e_st};
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: {ready,req,off,flush,stall} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic scramble(input logic noisy_valid);
        skip_valid = noisy_valid ? 1'($urandom) : 1'b0;
        skip_kind  = 3'($urandom);
        reg_a      = 8'($urandom);
        reg_b      = 8'($urandom);
        bit_sel    = 3'($urandom);
        next_long  = 1'($urandom);
        io_data    = 8'($urandom);
    endtask

    // issue one skip at the current negedge and follow it to idle
    task automatic run_skip(input logic [2:0] k, input logic [7:0] a, input logic [7:0] b,
                            input logic [2:0] i, input logic [7:0] io, input logic lng);
        logic [1:0] off;
        logic       is_io;
        off   = exp_offset(k, a, b, i, io, lng);
        is_io = (k >= 3'd3);
        chk("R2 ready before issue", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        skip_valid = 1'b1; skip_kind = k; reg_a = a; reg_b = b;
        bit_sel = i; next_long = lng; io_data = 8'($urandom);
        @(negedge clk);
        scramble(1'b1);
        if (is_io) begin
            io_data = io;
            chk("R8 stall cycle", 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
            @(negedge clk);
            scramble(1'b1);
        end
        chk(is_io ? "R5 R6 R8 I/O request" : "R3 R4 R6 R7 R10 register request",
            1'b0, 1'b1, off, 1'b0, 1'b0);
        @(negedge clk);
        scramble(1'b1);
        if (off != 2'd0) begin
            chk("R9 first flush", 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
            @(negedge clk);
            scramble(1'b1);
            chk("R9 second flush", 1'b0, 1'b0, 2'd0, 1'b1, 1'b0);
            @(negedge clk);
            scramble(1'b0);
        end
        skip_valid = 1'b0;
        chk("R7 R8 R9 R11 back to idle", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'h5C1F_0A3D));
        rst = 1'b1;
        scramble(1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset state", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        rst = 1'b0;

        // directed corners
        run_skip(3'd0, 8'h5A, 8'h5A, 3'd0, 8'h00, 1'b1);  // equal, two-word follower
        run_skip(3'd0, 8'h5A, 8'h5B, 3'd0, 8'h00, 1'b1);  // unequal
        run_skip(3'd1, 8'h7F, 8'h00, 3'd7, 8'h00, 1'b0);  // bit 7 clear
        run_skip(3'd2, 8'h01, 8'h00, 3'd0, 8'h00, 1'b1);  // bit 0 set
        run_skip(3'd2, 8'hFE, 8'h00, 3'd0, 8'h00, 1'b0);  // bit 0 not set
        run_skip(3'd3, 8'h00, 8'h00, 3'd3, 8'hF7, 1'b1);  // io bit 3 clear
        run_skip(3'd4, 8'hFF, 8'hFF, 3'd7, 8'h7F, 1'b0);  // io bit 7 not set
        run_skip(3'd4, 8'h00, 8'h00, 3'd6, 8'h40, 1'b0);  // io bit 6 set

        // R2: unknown class codes are ignored
        for (int c = 5; c < 8; c++) begin
            skip_valid = 1'b1; skip_kind = 3'(c);
            @(negedge clk);
            skip_valid = 1'b0;
            chk("R2 unknown class ignored", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);
        end

        // R1: reset in the middle of a taken I/O skip
        skip_valid = 1'b1; skip_kind = 3'd3; bit_sel = 3'd0; next_long = 1'b0;
        @(negedge clk);
        skip_valid = 1'b0;
        chk("R8 stall before reset", 1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset mid skip", 1'b1, 1'b0, 2'd0, 1'b0, 1'b0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0] k;
            logic [7:0] a, b;
            k = 3'($urandom_range(0, 4));
            a = 8'($urandom);
            b = ($urandom_range(0, 2) == 0) ? a : 8'($urandom);
            run_skip(k, a, b, 3'($urandom), 8'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule